// File: doc/BRIEF.md
# Character Display Fetch and Pattern Lookup

This block sits between a CPU and its memory and turns the display file into character patterns. The CPU runs the display area as if it were code. When an opcode fetch reads a displayable character from the upper half of the address space and the CPU is not halted, the block keeps the character code and hands the CPU a NOP (0x00) in place of the real byte. The memory byte itself is not changed.

In the refresh cycle that follows, the CPU drives a refresh address. The block builds the address of an external pattern ROM from that refresh address, the kept code and a 3-bit row counter. It takes the ROM's byte, inverts it when the character asks for that, and offers the result to a video shifter. The block also raises a one-cycle interrupt request whenever a refresh address has bit 6 low, which lets software count scan lines.

The model is synchronous, with one clock per bus cycle. `cpu_rdata` and `pat_addr` are combinational within their cycle. The video byte and the interrupt request are registered and appear one clock after their cycle. The video output is a valid/ready stream. `vid_valid` stays high with a stable byte until `vid_ready` is seen. The CPU cannot be stalled, so a newer pattern byte replaces one that has not been taken. When `vid_ready` is held high, each byte is a one-cycle strobe.

Top module: `charfetch`

## Requirements
- R1: A cycle with `m1`=1, `cpu_addr[15]`=1, `mem_rdata[6]`=0 and `halt`=0 is a capture. In that cycle `cpu_rdata` is 0x00, and the block keeps `mem_rdata` as the character code.
- R2: In every cycle that is not a capture, `cpu_rdata` equals `mem_rdata`. This covers data with bit 6 set, addresses with bit 15 clear, and a halted CPU.
- R3: During a cycle with `rfsh`=1, `pat_addr[15:9]` is `cpu_addr[15:9]`, `pat_addr[8:3]` is code bits 5..0 and `pat_addr[2:0]` is `row`.
- R4: If bit 7 of the kept code is 1, the delivered video byte is the bitwise inverse of `rom_data`.
- R5: A refresh cycle while a code is held makes `vid_valid` 1 in the next cycle. If code bit 7 is 0, `vid_byte` equals `rom_data` as sampled in that refresh cycle. The held flag is then cleared, so each capture gives exactly one byte.
- R6: A refresh cycle with no code held produces no video byte.
- R7: `irq` is 1 in the cycle after a refresh cycle with `cpu_addr[6]`=0, and 0 after every other cycle.
- R8: While `vid_valid`=1 and `vid_ready`=0, `vid_valid` stays 1 and `vid_byte` does not change, unless a new delivery replaces the byte. A cycle with `vid_ready`=1 and no new delivery drops `vid_valid`.
- R9: After reset, `vid_valid` and `irq` are 0 and no code is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, or the refresh address when `rfsh` is 1 |
| mem_rdata | input | 8 | Byte read from memory |
| m1 | input | 1 | Opcode fetch cycle |
| rfsh | input | 1 | Refresh cycle |
| halt | input | 1 | CPU halted |
| row | input | 3 | Character row counter |
| cpu_rdata | output | 8 | Data returned to the CPU |
| pat_addr | output | 16 | Pattern ROM address |
| rom_data | input | 8 | Pattern ROM byte |
| vid_byte | output | 8 | Pattern byte for the shifter |
| vid_valid | output | 1 | Video byte valid |
| vid_ready | input | 1 | Shifter accepts the byte |
| irq | output | 1 | One-cycle interrupt request |

## Verification
On every cycle, the assertions check the following: the NOP substitution and the pass-through on the CPU data path, and the high and row fields of the pattern address. They also check that the interrupt request follows a refresh with address bit 6 low, that a video byte only appears after a refresh cycle, and that a stalled video byte holds. Some behaviours depend on state carried between cycles. These are the pairing of one capture with exactly one byte, the code field of the pattern address, the inversion chosen by the kept bit 7, and the absence of a byte on a second refresh. Only the bench's reference model, run over directed and random cycle sequences, can show them.

// File: rtl/charfetch_pkg.sv
package charfetch_pkg;
  typedef enum logic [1:0] {
    CYC_OTHER   = 2'd0,
    CYC_FETCH   = 2'd1,
    CYC_REFRESH = 2'd2
  } cyc_kind_e;

  function automatic cyc_kind_e classify(input logic m1, input logic rfsh);
    if (rfsh)    return CYC_REFRESH;
    else if (m1) return CYC_FETCH;
    else         return CYC_OTHER;
  endfunction
endpackage

// File: rtl/charfetch_capture.sv
module charfetch_capture #(
  parameter int DW       = 8,
  parameter int DISP_BIT = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  charfetch_pkg::cyc_kind_e kind,
  input  logic                     addr_top,
  input  logic                     halt,
  input  logic [DW-1:0]            mem_rdata,
  output logic [DW-1:0]            cpu_rdata,
  output logic [DW-1:0]            code_q,
  output logic                     held_q
);
  import charfetch_pkg::*;

  logic take;

  // Displayable: fetch in upper half, marker bit clear, CPU running
  assign take = (kind == CYC_FETCH) && addr_top && !mem_rdata[DISP_BIT] && !halt;

  assign cpu_rdata = take ? '0 : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (take) begin
        held_q <= 1'b1;
        code_q <= mem_rdata;
      end else if (kind == CYC_REFRESH) begin
        held_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/charfetch_pattern.sv
module charfetch_pattern #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int CODE_W  = 6,
  parameter int ROW_W   = 3,
  parameter int INV_BIT = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        refresh,
  input  logic                        held,
  input  logic [DW-1:0]               code,
  input  logic [AW-1:CODE_W+ROW_W]    addr_hi,
  input  logic [ROW_W-1:0]            row,
  input  logic [DW-1:0]               rom_data,
  output logic [AW-1:0]               pat_addr,
  output logic [DW-1:0]               vid_byte,
  output logic                        vid_valid,
  input  logic                        vid_ready
);
  localparam int LOW_W = CODE_W + ROW_W;

  logic          deliver;
  logic [DW-1:0] shaped;

  assign pat_addr = {addr_hi, code[CODE_W-1:0], row};
  assign deliver  = refresh && held;

  for (genvar b = 0; b < DW; b++) begin : g_inv
    assign shaped[b] = rom_data[b] ^ code[INV_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_valid <= 1'b0;
      vid_byte  <= '0;
    end else if (deliver) begin
      vid_valid <= 1'b1;
      vid_byte  <= shaped;
    end else if (vid_ready) begin
      vid_valid <= 1'b0;
    end
  end

  logic unused_pat;
  assign unused_pat = ^{LOW_W[0]};
endmodule

// File: rtl/charfetch.sv
module charfetch #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CODE_W   = 6,
  parameter int ROW_W    = 3,
  parameter int DISP_BIT = 6,
  parameter int INV_BIT  = 7,
  parameter int IRQ_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          m1,
  input  logic          rfsh,
  input  logic          halt,
  input  logic [ROW_W-1:0] row,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] pat_addr,
  input  logic [DW-1:0] rom_data,
  output logic [DW-1:0] vid_byte,
  output logic          vid_valid,
  input  logic          vid_ready,
  output logic          irq
);
  import charfetch_pkg::*;

  localparam int HI_LSB = CODE_W + ROW_W;

  cyc_kind_e     kind;
  logic [DW-1:0] code_q;
  logic          held_q;

  assign kind = classify(m1, rfsh);

  charfetch_capture #(.DW(DW), .DISP_BIT(DISP_BIT)) u_cap (
    .clk(clk), .rst_n(rst_n), .kind(kind), .addr_top(cpu_addr[AW-1]),
    .halt(halt), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
    .code_q(code_q), .held_q(held_q)
  );

  charfetch_pattern #(.AW(AW), .DW(DW), .CODE_W(CODE_W), .ROW_W(ROW_W),
                      .INV_BIT(INV_BIT)) u_pat (
    .clk(clk), .rst_n(rst_n), .refresh(kind == CYC_REFRESH), .held(held_q),
    .code(code_q), .addr_hi(cpu_addr[AW-1:HI_LSB]), .row(row),
    .rom_data(rom_data), .pat_addr(pat_addr), .vid_byte(vid_byte),
    .vid_valid(vid_valid), .vid_ready(vid_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (kind == CYC_REFRESH) && !cpu_addr[IRQ_BIT];
  end

  logic unused_top;
  assign unused_top = ^{cpu_addr};
endmodule

// File: rtl/charfetch_chk.sv
module charfetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  mem_rdata,
  input logic        m1,
  input logic        rfsh,
  input logic        halt,
  input logic [2:0]  row,
  input logic [7:0]  cpu_rdata,
  input logic [15:0] pat_addr,
  input logic [7:0]  vid_byte,
  input logic        vid_valid,
  input logic        vid_ready,
  input logic        irq
);
  logic cap;
  assign cap = m1 && !rfsh && cpu_addr[15] && !mem_rdata[6] && !halt;

  AST_NOP_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> cpu_rdata == 8'h00); // R1
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |-> cpu_rdata == mem_rdata); // R2
  AST_PAT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh |-> (pat_addr[15:9] == cpu_addr[15:9] && pat_addr[2:0] == row)); // R3
  AST_IRQ_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh && !cpu_addr[6]) |=> irq); // R7
  AST_IRQ_ONLY_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh && !cpu_addr[6]) |=> !irq); // R7
  AST_BYTE_NEEDS_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh && !(vid_valid && !vid_ready) |=> !vid_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_valid && !vid_ready && !rfsh) |=> (vid_valid && $stable(vid_byte))); // R8
endmodule

bind charfetch charfetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rdata(mem_rdata),
  .m1(m1), .rfsh(rfsh), .halt(halt), .row(row), .cpu_rdata(cpu_rdata),
  .pat_addr(pat_addr), .vid_byte(vid_byte), .vid_valid(vid_valid),
  .vid_ready(vid_ready), .irq(irq)
);

// File: tb/tb_charfetch.sv
module tb_charfetch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  mem_rdata;
  logic        m1, rfsh, halt;
  logic [2:0]  row;
  logic [7:0]  cpu_rdata;
  logic [15:0] pat_addr;
  logic [7:0]  rom_data;
  logic [7:0]  vid_byte;
  logic        vid_valid;
  logic        vid_ready;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model state
  bit       m_held = 0;
  bit [7:0] m_code = 0;
  bit       m_valid = 0;
  bit [7:0] m_byte = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rom_data = rom_fn(pat_addr);

  charfetch dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rdata(mem_rdata),
    .m1(m1), .rfsh(rfsh), .halt(halt), .row(row), .cpu_rdata(cpu_rdata),
    .pat_addr(pat_addr), .rom_data(rom_data), .vid_byte(vid_byte),
    .vid_valid(vid_valid), .vid_ready(vid_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check combinational, then registered.
  task automatic bus(input logic [15:0] a, input logic [7:0] d, input bit im1,
                     input bit irf, input bit ih, input logic [2:0] r, input bit rdy);
    bit cap, dlv, exp_irq;
    logic [15:0] ea;
    @(negedge clk);
    cpu_addr = a; mem_rdata = d; m1 = im1; rfsh = irf; halt = ih; row = r;
    vid_ready = rdy;
    #2;
    cap = im1 && !irf && a[15] && !d[6] && !ih;
    if (cap) chk("R1", cpu_rdata, 8'h00);
    else     chk("R2", cpu_rdata, d);
    ea = {a[15:9], m_code[5:0], r};
    if (irf) chk("R3", pat_addr, ea);
    dlv = irf && m_held;
    exp_irq = irf && !a[6];
    if (dlv) begin
      m_valid = 1;
      m_byte  = rom_fn(ea) ^ (m_code[7] ? 8'hFF : 8'h00);
    end else if (rdy) m_valid = 0;
    if (cap) begin m_held = 1; m_code = d; end
    else if (irf) m_held = 0;
    @(posedge clk); #1;
    chk("R7", irq, exp_irq);
    if (dlv) chk("R5", vid_valid, 1);
    else if (irf) chk("R6", vid_valid, m_valid);
    else chk("R8", vid_valid, m_valid);
    if (m_valid) chk(m_code[7] ? "R4" : "R5", vid_byte, m_byte);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cpu_addr = 0; mem_rdata = 0; m1 = 0; rfsh = 0; halt = 0;
    row = 0; vid_ready = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", vid_valid, 0);
    chk("R9", irq, 0);
    @(negedge clk); rst_n = 1;
    // R9: no held code -> refresh gives no byte
    bus(16'hC000, 8'h00, 0, 1, 0, 3'd0, 1);
    // R1 + R3 + R5 directed: code 0x25, refresh 0xA400 row 5
    bus(16'h8010, 8'h25, 1, 0, 0, 3'd0, 1);
    bus(16'hA400, 8'h00, 0, 1, 0, 3'd5, 1);
    chk("R3", {16'hA400 & 16'hFE00} | (16'h25 << 3) | 16'd5, 16'hA52D);
    // R6: second refresh without a new capture
    bus(16'hA440, 8'h00, 0, 1, 0, 3'd5, 1);
    // R4: inverted char, ready low to show R8 hold
    bus(16'h9000, 8'hA3, 1, 0, 0, 3'd0, 0);
    bus(16'h1240, 8'h00, 0, 1, 0, 3'd2, 0);
    bus(16'h0000, 8'h11, 0, 0, 0, 3'd2, 0);
    bus(16'h0000, 8'h11, 0, 0, 0, 3'd2, 1);
    // R2: bit 6 set, low address, halted
    bus(16'h8000, 8'h45, 1, 0, 0, 3'd0, 1);
    bus(16'h7000, 8'h05, 1, 0, 0, 3'd0, 1);
    bus(16'hF000, 8'h05, 1, 0, 1, 3'd0, 1);
    bus(16'hF000, 8'h05, 0, 0, 0, 3'd0, 1);
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, 3);
      bus(16'($urandom), 8'($urandom), k == 0 || k == 3, k == 1, k == 3,
          3'($urandom), $urandom_range(0, 3) != 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule